// File: doc/BRIEF.md
# Unlock Sequence Command Decoder

This block watches a stream of synchronous write events, each an address and a data byte, and picks out the multi-write unlock sequences that a byte-wide nonvolatile memory uses to guard its write and service operations. It recognises two families of sequences. Both share a two-write key. The short family adds one opcode write. The long family adds an extension opcode, the key again, and a final opcode. Each recognised sequence produces a one-cycle command pulse. The five commands are protected page write, protection off, chip erase, identification entry and identification exit.

The decoder keeps two sticky flags. The first is a global write-protect flag. Issuing a protected page write sets this flag and also opens a page-load window for the data bytes that follow. The second is an identification-mode flag. While it is set, a read port returns fixed manufacturer and device codes. Writes that break a sequence send the recogniser back to idle. Such a write reaches the data output only while protection is off. Writes made inside an open page-load window always pass through as data. The window closes after a parameterised number of idle cycles, and at that point the decoder emits a load-done pulse. Erase timing, the page buffer and the array itself live outside this block.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, prot_on, id_mode, page_open, load_done, pass_valid and all five command pulses are 0.
- R2: Key and opcode addresses are compared on wr_addr[14:0] only. wr_addr[15] never changes the result, and 0x5554 in place of 0x5555 is a mismatch.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h give a cmd_prot_write pulse in the cycle after the last write, with prot_on=1 and page_open=1 from that cycle on. None of the three writes is passed through.
- R4: While page_open=1, every write appears on pass_valid/pass_addr/pass_data one cycle later and is not decoded as a command. The window closes LOAD_GAP cycles after the last write, or after the A0h write if no data follows. At that point page_open falls and load_done pulses for one cycle.
- R5: The key, 80h@5555h, the key again, then 20h@5555h give a cmd_prot_off pulse and clear prot_on.
- R6: The same six-write form ending in 10h@5555h gives a cmd_erase pulse and leaves prot_on unchanged.
- R7: The key followed by 90h@5555h, or the six-write form ending in 60h@5555h, pulses cmd_id_enter and sets id_mode. The key followed by F0h@5555h pulses cmd_id_exit and clears id_mode. Reset clears id_mode.
- R8: With id_mode=1, a read address whose bits [14:1] are zero gives id_hit=1, with id_rdata=BFh when bit 0 is 0 and 5Dh when bit 0 is 1. Any other address, or id_mode=0, gives id_hit=0 and id_rdata=00h.
- R9: A write that does not match the expected next step returns the recogniser to idle and produces no command. That write is passed through one cycle later if prot_on=0 and is dropped if prot_on=1. The writes of a sequence that was matched so far are never passed through.
- R10: At most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, also models power loss |
| wr_valid | input | 1 | Write event strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address for the identification codes |
| pass_valid | output | 1 | A data write is forwarded |
| pass_addr | output | ADDR_W | Address of the forwarded write |
| pass_data | output | 8 | Data of the forwarded write |
| cmd_prot_write | output | 1 | Protected page write pulse |
| cmd_prot_off | output | 1 | Protection disable pulse |
| cmd_erase | output | 1 | Chip erase pulse |
| cmd_id_enter | output | 1 | Identification entry pulse |
| cmd_id_exit | output | 1 | Identification exit pulse |
| prot_on | output | 1 | Global write-protect flag |
| id_mode | output | 1 | Identification mode flag |
| page_open | output | 1 | Page-load window open |
| load_done | output | 1 | Pulse when the page-load window closes |
| id_hit | output | 1 | Read address hits an identification code |
| id_rdata | output | 8 | Identification code |

## Verification
Command pulses, flag changes and forwarded writes are all registered on the clock edge that samples the write, so they are due exactly one cycle after that write. The bench drives each write on a falling edge and samples every output on the next falling edge, then compares all flags and pulses against a value it builds from the requirement. Closing the window takes LOAD_GAP idle edges, so the bench checks that page_open is still high after LOAD_GAP-1 idle cycles and that the close is seen after one more. The identification read path is combinational and is checked within the same cycle as the address change.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam int CMP_W  = 15;
  localparam int DATA_W = 8;
  localparam int NCMD   = 5;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_EXT3, SQ_EXT4, SQ_EXT5
  } seq_state_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PROT_WR, CMD_PROT_OFF, CMD_ERASE, CMD_ID_ON, CMD_ID_OFF
  } cmd_t;

  localparam logic [CMP_W-1:0]  KEY_HI      = 15'h5555;
  localparam logic [CMP_W-1:0]  KEY_LO      = 15'h2AAA;
  localparam logic [DATA_W-1:0] UNLOCK_A    = 8'hAA;
  localparam logic [DATA_W-1:0] UNLOCK_B    = 8'h55;
  localparam logic [DATA_W-1:0] OP_PROT_WR  = 8'hA0;
  localparam logic [DATA_W-1:0] OP_EXTEND   = 8'h80;
  localparam logic [DATA_W-1:0] OP_ID_ON    = 8'h90;
  localparam logic [DATA_W-1:0] OP_ID_OFF   = 8'hF0;
  localparam logic [DATA_W-1:0] OP_PROT_OFF = 8'h20;
  localparam logic [DATA_W-1:0] OP_ERASE    = 8'h10;
  localparam logic [DATA_W-1:0] OP_ID_ALT   = 8'h60;
  localparam logic [DATA_W-1:0] MFR_CODE    = 8'hBF;
  localparam logic [DATA_W-1:0] DEV_CODE    = 8'h5D;

  // True when the compared address bits equal the key and the data matches.
  function automatic logic step_hit(input logic [CMP_W-1:0] a,
                                    input logic [DATA_W-1:0] d,
                                    input logic [CMP_W-1:0] key,
                                    input logic [DATA_W-1:0] val);
    return (a == key) && (d == val);
  endfunction

  // Opcode that completes a three-write sequence.
  function automatic cmd_t short_op(input logic [DATA_W-1:0] d);
    case (d)
      OP_PROT_WR: return CMD_PROT_WR;
      OP_ID_ON:   return CMD_ID_ON;
      OP_ID_OFF:  return CMD_ID_OFF;
      default:    return CMD_NONE;
    endcase
  endfunction

  // Opcode that completes a six-write sequence.
  function automatic cmd_t long_op(input logic [DATA_W-1:0] d);
    case (d)
      OP_PROT_OFF: return CMD_PROT_OFF;
      OP_ERASE:    return CMD_ERASE;
      OP_ID_ALT:   return CMD_ID_ON;
      default:     return CMD_NONE;
    endcase
  endfunction

  // {hit, code} for an identification read.
  function automatic logic [DATA_W:0] id_lookup(input logic [CMP_W-1:0] a);
    if (a[CMP_W-1:1] != '0) return {1'b0, {DATA_W{1'b0}}};
    return a[0] ? {1'b1, DEV_CODE} : {1'b1, MFR_CODE};
  endfunction

endpackage

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
  import ucd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CMP_W-1:0]    wr_key,
  input  logic [DATA_W-1:0]   wr_data,
  output cmd_t                seq_cmd,
  output logic                seq_abort
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    seq_cmd   = CMD_NONE;
    seq_abort = 1'b0;
    if (wr_en) begin
      state_d = SQ_IDLE;
      case (state_q)
        SQ_IDLE: begin
          if (step_hit(wr_key, wr_data, KEY_HI, UNLOCK_A)) state_d = SQ_KEY1;
          else seq_abort = 1'b1;
        end
        SQ_KEY1: begin
          if (step_hit(wr_key, wr_data, KEY_LO, UNLOCK_B)) state_d = SQ_KEY2;
          else seq_abort = 1'b1;
        end
        SQ_KEY2: begin
          if (step_hit(wr_key, wr_data, KEY_HI, OP_EXTEND)) state_d = SQ_EXT3;
          else if (wr_key == KEY_HI && short_op(wr_data) != CMD_NONE)
            seq_cmd = short_op(wr_data);
          else seq_abort = 1'b1;
        end
        SQ_EXT3: begin
          if (step_hit(wr_key, wr_data, KEY_HI, UNLOCK_A)) state_d = SQ_EXT4;
          else seq_abort = 1'b1;
        end
        SQ_EXT4: begin
          if (step_hit(wr_key, wr_data, KEY_LO, UNLOCK_B)) state_d = SQ_EXT5;
          else seq_abort = 1'b1;
        end
        SQ_EXT5: begin
          if (wr_key == KEY_HI && long_op(wr_data) != CMD_NONE)
            seq_cmd = long_op(wr_data);
          else seq_abort = 1'b1;
        end
        default: seq_abort = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ucd_mode_regs.sv
module ucd_mode_regs
  import ucd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_t            seq_cmd,
  output logic [NCMD-1:0] cmd_pulse,
  output logic            prot_on,
  output logic            id_mode
);

  logic [NCMD-1:0] cmd_dec;

  // Bit i of the pulse vector stands for command code i+1.
  for (genvar g = 0; g < NCMD; g++) begin : g_dec
    assign cmd_dec[g] = (seq_cmd == cmd_t'(3'(g + 1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_pulse <= '0;
      prot_on   <= 1'b0;
      id_mode   <= 1'b0;
    end else begin
      cmd_pulse <= cmd_dec;
      if (seq_cmd == CMD_PROT_WR)       prot_on <= 1'b1;
      else if (seq_cmd == CMD_PROT_OFF) prot_on <= 1'b0;
      if (seq_cmd == CMD_ID_ON)         id_mode <= 1'b1;
      else if (seq_cmd == CMD_ID_OFF)   id_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/ucd_page_window.sv
module ucd_page_window #(
  parameter int LOAD_GAP = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic wr_valid,
  output logic page_open,
  output logic load_done
);

  localparam int CNT_W = $clog2(LOAD_GAP + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_GAP - 1);

  logic [CNT_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_open <= 1'b0;
      load_done <= 1'b0;
      idle_q    <= '0;
    end else begin
      load_done <= 1'b0;
      if (open_req) begin
        page_open <= 1'b1;
        idle_q    <= '0;
      end else if (page_open) begin
        if (wr_valid) begin
          idle_q <= '0;
        end else if (idle_q == LAST) begin
          page_open <= 1'b0;
          load_done <= 1'b1;
          idle_q    <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ucd_id_rom.sv
module ucd_id_rom
  import ucd_pkg::*;
(
  input  logic              id_mode,
  input  logic [CMP_W-1:0]  rd_key,
  output logic              id_hit,
  output logic [DATA_W-1:0] id_rdata
);

  logic [DATA_W:0] look;

  always_comb begin
    look = id_lookup(rd_key);
    if (!id_mode) look = '0;
    id_hit   = look[DATA_W];
    id_rdata = look[DATA_W-1:0];
  end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LOAD_GAP = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              pass_valid,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [7:0]        pass_data,
  output logic              cmd_prot_write,
  output logic              cmd_prot_off,
  output logic              cmd_erase,
  output logic              cmd_id_enter,
  output logic              cmd_id_exit,
  output logic              prot_on,
  output logic              id_mode,
  output logic              page_open,
  output logic              load_done,
  output logic              id_hit,
  output logic [7:0]        id_rdata
);

  // Named internal events, visible to the bound checker.
  logic            fsm_wr;
  cmd_t            seq_cmd;
  logic            seq_abort;
  logic            pass_now;
  logic [NCMD-1:0] cmd_pulse;

  assign fsm_wr   = wr_valid && !page_open;
  assign pass_now = wr_valid && (page_open || (seq_abort && !prot_on));

  ucd_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fsm_wr),
    .wr_key    (wr_addr[CMP_W-1:0]),
    .wr_data   (wr_data),
    .seq_cmd   (seq_cmd),
    .seq_abort (seq_abort)
  );

  ucd_mode_regs u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_cmd   (seq_cmd),
    .cmd_pulse (cmd_pulse),
    .prot_on   (prot_on),
    .id_mode   (id_mode)
  );

  ucd_page_window #(.LOAD_GAP(LOAD_GAP)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_req  (seq_cmd == CMD_PROT_WR),
    .wr_valid  (wr_valid),
    .page_open (page_open),
    .load_done (load_done)
  );

  ucd_id_rom u_id (
    .id_mode  (id_mode),
    .rd_key   (rd_addr[CMP_W-1:0]),
    .id_hit   (id_hit),
    .id_rdata (id_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_valid <= 1'b0;
      pass_addr  <= '0;
      pass_data  <= '0;
    end else begin
      pass_valid <= pass_now;
      if (pass_now) begin
        pass_addr <= wr_addr;
        pass_data <= wr_data;
      end
    end
  end

  assign cmd_prot_write = cmd_pulse[0];
  assign cmd_prot_off   = cmd_pulse[1];
  assign cmd_erase      = cmd_pulse[2];
  assign cmd_id_enter   = cmd_pulse[3];
  assign cmd_id_exit    = cmd_pulse[4];

endmodule

// File: rtl/ucd_checker.sv
module ucd_checker #(
  parameter int LOAD_GAP = 12
) (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic seq_abort,
  input logic pass_valid,
  input logic cmd_prot_write,
  input logic cmd_prot_off,
  input logic cmd_erase,
  input logic cmd_id_enter,
  input logic cmd_id_exit,
  input logic prot_on,
  input logic id_mode,
  input logic page_open,
  input logic load_done,
  input logic id_hit
);

  int unsigned idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !page_open || wr_valid) idle_cnt <= 0;
    else                                  idle_cnt <= idle_cnt + 1;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_prot_write, cmd_prot_off, cmd_erase, cmd_id_enter, cmd_id_exit})); // R10
  AST_PROT_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_prot_write |-> prot_on && page_open); // R3
  AST_PROT_OFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_prot_off |-> !prot_on); // R5
  AST_ERASE_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_erase |-> prot_on == $past(prot_on)); // R6
  AST_ID_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_id_enter |-> id_mode); // R7
  AST_ID_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_id_exit |-> !id_mode); // R7
  AST_ID_HIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> id_mode); // R8
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    page_open |-> idle_cnt < LOAD_GAP); // R4
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !page_open); // R4
  AST_PASS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> $past(page_open) || !$past(prot_on)); // R9
  AST_ABORT_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> !(cmd_prot_write || cmd_prot_off || cmd_erase || cmd_id_enter || cmd_id_exit)); // R9

endmodule

bind unlock_cmd_decoder ucd_checker #(.LOAD_GAP(LOAD_GAP)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_valid       (wr_valid),
  .seq_abort      (seq_abort),
  .pass_valid     (pass_valid),
  .cmd_prot_write (cmd_prot_write),
  .cmd_prot_off   (cmd_prot_off),
  .cmd_erase      (cmd_erase),
  .cmd_id_enter   (cmd_id_enter),
  .cmd_id_exit    (cmd_id_exit),
  .prot_on        (prot_on),
  .id_mode        (id_mode),
  .page_open      (page_open),
  .load_done      (load_done),
  .id_hit         (id_hit)
);

// File: tb/test_unlock_cmd_decoder.sv
`timescale 1ns/1ps
module test_unlock_cmd_decoder;

  localparam int GAP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic        pass_valid;
  logic [15:0] pass_addr;
  logic [7:0]  pass_data;
  logic        cmd_prot_write, cmd_prot_off, cmd_erase, cmd_id_enter, cmd_id_exit;
  logic        prot_on, id_mode, page_open, load_done, id_hit;
  logic [7:0]  id_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  unlock_cmd_decoder #(.ADDR_W(16), .LOAD_GAP(GAP)) i_unlock_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .pass_valid(pass_valid),
    .pass_addr(pass_addr), .pass_data(pass_data),
    .cmd_prot_write(cmd_prot_write), .cmd_prot_off(cmd_prot_off),
    .cmd_erase(cmd_erase), .cmd_id_enter(cmd_id_enter), .cmd_id_exit(cmd_id_exit),
    .prot_on(prot_on), .id_mode(id_mode), .page_open(page_open),
    .load_done(load_done), .id_hit(id_hit), .id_rdata(id_rdata)
  );

  // Observed vector: {pass, pw, poff, erase, id_on, id_off, prot, id, open, done}
  function automatic logic [9:0] obs();
    return {pass_valid, cmd_prot_write, cmd_prot_off, cmd_erase, cmd_id_enter,
            cmd_id_exit, prot_on, id_mode, page_open, load_done};
  endfunction

  function automatic logic [9:0] mk(input bit pv, input bit pw, input bit po,
                                    input bit er, input bit ie, input bit ix,
                                    input bit pr, input bit id, input bit op,
                                    input bit ld);
    return {pv, pw, po, er, ie, ix, pr, id, op, ld};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_obs(input string req, input string what, input logic [9:0] exp);
    check(obs() === exp, req, what, int'(obs()), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive a write at a falling edge; outputs are sampled one falling edge later.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key(input bit hi15);
    wr({hi15, 15'h5555}, 8'hAA);
    wr({hi15, 15'h2AAA}, 8'h55);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk_obs("R1", "reset state", '0);

    // R1: reset also clears identification mode
    key(1'b0); wr(16'h5555, 8'h90);
    chk_obs("R7", "id entry", mk(0,0,0,0,1,0,0,1,0,0));
    do_reset();
    @(negedge clk);
    chk_obs("R1", "reset clears id_mode", '0);

    // Sweep of the opcode after the key, protection off (R3 R7 R9 R2)
    for (int d = 0; d < 256; d++) begin
      logic hb;
      hb = d[0];
      do_reset();
      wr({hb, 15'h5555}, 8'hAA);
      chk_obs("R9", "first key write not passed", '0);
      wr({~hb, 15'h2AAA}, 8'h55);
      chk_obs("R9", "second key write not passed", '0);
      wr({hb, 15'h5555}, 8'(d));
      if (d == 8'hA0) begin
        chk_obs("R3", "protected write opens", mk(0,1,0,0,0,0,1,0,1,0));
      end else if (d == 8'h90) begin
        chk_obs("R7", "id entry", mk(0,0,0,0,1,0,0,1,0,0));
      end else if (d == 8'hF0) begin
        chk_obs("R7", "id exit", mk(0,0,0,0,0,1,0,0,0,0));
      end else if (d == 8'h80) begin
        chk_obs("R9", "extension pending", '0);
        wr(16'h0000, 8'h00);
        chk_obs("R9", "break after extension passes", mk(1,0,0,0,0,0,0,0,0,0));
      end else begin
        chk_obs("R9", "mismatch passes with prot off", mk(1,0,0,0,0,0,0,0,0,0));
        check(pass_data == 8'(d) && pass_addr == {hb, 15'h5555}, "R9",
              "passed addr/data", int'({pass_addr, pass_data}), int'({hb, 15'h5555, 8'(d)}));
      end
    end

    // Sweep of the final opcode of the six-write form, protection on (R5 R6 R7 R9)
    for (int d = 0; d < 256; d++) begin
      do_reset();
      key(1'b0); wr(16'h5555, 8'hA0);
      idle(GAP);
      key(1'b0); wr(16'h5555, 8'h80);
      key(1'b1); wr(16'hD555, 8'(d));
      if (d == 8'h20)
        chk_obs("R5", "protection off", mk(0,0,1,0,0,0,0,0,0,0));
      else if (d == 8'h10)
        chk_obs("R6", "erase keeps prot", mk(0,0,0,1,0,0,1,0,0,0));
      else if (d == 8'h60)
        chk_obs("R7", "alternate id entry", mk(0,0,0,0,1,0,1,1,0,0));
      else
        chk_obs("R9", "mismatch dropped with prot on", mk(0,0,0,0,0,0,1,0,0,0));
    end

    // Erase with protection off leaves it off (R6)
    do_reset();
    key(1'b0); wr(16'h5555, 8'h80); key(1'b0); wr(16'h5555, 8'h10);
    chk_obs("R6", "erase with prot off", mk(0,0,0,1,0,0,0,0,0,0));

    // Near-miss address is a mismatch (R2)
    do_reset();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5554, 8'hA0);
    chk_obs("R2", "0x5554 is not a key", mk(1,0,0,0,0,0,0,0,0,0));

    // Mismatch restarts nothing: a lone key tail passes (R9)
    do_reset();
    wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55);
    chk_obs("R9", "broken key passes", mk(1,0,0,0,0,0,0,0,0,0));
    wr(16'h5555, 8'hA0);
    chk_obs("R9", "opcode without key passes", mk(1,0,0,0,0,0,0,0,0,0));

    // Page window: data passes, commands ignored, close after GAP idle edges (R4)
    do_reset();
    key(1'b0); wr(16'h5555, 8'hA0);
    for (int i = 0; i < 3; i++) begin
      wr(16'h1200 + 16'(i), 8'h30 + 8'(i));
      chk_obs("R4", "window data passes", mk(1,0,0,0,0,0,1,0,1,0));
      check(pass_data == 8'h30 + 8'(i), "R4", "window data", pass_data, 8'h30 + i);
    end
    wr(16'h5555, 8'hAA);
    chk_obs("R4", "key byte in window is data", mk(1,0,0,0,0,0,1,0,1,0));
    wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h90);
    chk_obs("R4", "opcode in window not decoded", mk(1,0,0,0,0,0,1,0,1,0));
    idle(GAP - 1);
    chk_obs("R4", "window still open", mk(0,0,0,0,0,0,1,0,1,0));
    idle(1);
    chk_obs("R4", "window closes", mk(0,0,0,0,0,0,1,0,0,1));
    idle(1);
    chk_obs("R4", "done is one cycle", mk(0,0,0,0,0,0,1,0,0,0));
    wr(16'h0042, 8'h42);
    chk_obs("R9", "stray write dropped when protected", mk(0,0,0,0,0,0,1,0,0,0));

    // Window with no data closes GAP edges after the opcode (R4)
    do_reset();
    key(1'b0); wr(16'h5555, 8'hA0);
    idle(GAP - 1);
    check(page_open == 1'b1, "R4", "empty window open", page_open, 1);
    idle(1);
    check(page_open == 1'b0 && load_done == 1'b1, "R4", "empty window close",
          {page_open, load_done}, 1);

    // Identification reads (R8)
    do_reset();
    rd_addr = 16'h0000; #0.1;
    check(id_hit == 1'b0 && id_rdata == 8'h00, "R8", "no id outside mode", {id_hit, id_rdata}, 0);
    key(1'b0); wr(16'h5555, 8'h90);
    for (int a = 0; a < 8; a++) begin
      for (int h = 0; h < 2; h++) begin
        logic [8:0] e;
        rd_addr = {1'(h), 15'(a)};
        #0.1;
        e = (a == 0) ? 9'h1BF : (a == 1) ? 9'h15D : 9'h000;
        check({id_hit, id_rdata} == e, "R8", "id read", int'({id_hit, id_rdata}), int'(e));
      end
    end
    rd_addr = 16'h4000; #0.1;
    check(id_hit == 1'b0, "R8", "high address no hit", id_hit, 0);
    @(negedge clk);
    key(1'b0); wr(16'h5555, 8'hF0);
    rd_addr = 16'h0001; #0.1;
    check(id_hit == 1'b0 && id_mode == 1'b0, "R8", "exit clears reads", {id_hit, id_mode}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule